// File: doc/BRIEF.md
# Multi-Channel DMA Request Arbiter

This block decides which of several peripheral DMA channels may drive a shared transfer engine. Every channel keeps four single-bit attributes: enable, request mask, high priority and use-burst. Software changes each attribute through its own pair of set and clear strobes. A channel also holds a remaining item count and a burst exponent, both loaded through a small configuration write port. A channel can be triggered by a peripheral burst request, by a peripheral single request, or by a software request that stays pending until the channel is granted.

Once a channel wins, it keeps ownership for up to 2^k items. The value k is its exponent, limited to 10. The burst also ends early if the channel's count runs out. Ownership is then dropped for one cycle so that the arbiter can choose again. The engine moves one item in every cycle in which the grant is visible, and `item_stb_o` marks each of those cycles. The processor always has first call on the bus: while `cpu_bus_busy_i` is high, no grant is shown and the burst simply waits. When a channel's count reaches zero, that channel gets a one-cycle done pulse and its enable is cleared.

Top module: `dma_req_arbiter`

## Requirements
- R1: After reset, `grant_o`, `item_stb_o` and `done_o` are all zero, and every attribute bit, item count and pending software request is cleared. A request made to a channel after reset therefore gets no grant.
- R2: Each attribute bit is set by its set strobe and cleared by its clear strobe. When both strobes are high in the same cycle, clear wins.
- R3: A channel can be granted only if it is enabled and its remaining count is nonzero. In addition, it needs an accepted request from a peripheral or from software.
- R4: While a channel's mask bit is set, its peripheral requests are ignored. A software request on that channel is still accepted.
- R5: While a channel's use-burst bit is set, its single requests are ignored and only its burst request is served.
- R6: High-priority eligible channels always beat default-priority ones. Within the winning level, the lowest channel index wins.
- R7: A burst moves min(2^min(k,10), remaining) items from one channel. After the burst, at least one cycle without a grant follows before any new grant.
- R8: While `cpu_bus_busy_i` is high, `grant_o` and `item_stb_o` are zero. A burst paused this way resumes afterwards with no item lost.
- R9: When a channel's last item is strobed, that channel's bit of `done_o` is high for exactly the next cycle, and its enable bit is cleared.
- R10: `grant_o` has at most one bit set. `item_stb_o` is high exactly when `grant_o` is nonzero.
- R11: A software request pulse stays pending until the channel is granted. This holds even if the channel cannot be granted at the time of the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_set_i | input | N_CH | Set strobes for the enable bits |
| en_clr_i | input | N_CH | Clear strobes for the enable bits |
| mask_set_i | input | N_CH | Set strobes for the request-mask bits |
| mask_clr_i | input | N_CH | Clear strobes for the request-mask bits |
| prio_set_i | input | N_CH | Set strobes for the high-priority bits |
| prio_clr_i | input | N_CH | Clear strobes for the high-priority bits |
| burst_set_i | input | N_CH | Set strobes for the use-burst bits |
| burst_clr_i | input | N_CH | Clear strobes for the use-burst bits |
| cfg_we_i | input | 1 | Load the exponent and count of one channel |
| cfg_ch_i | input | IDX_W | Channel selected by the configuration write |
| cfg_exp_i | input | 4 | Burst exponent k (values above 10 act as 10) |
| cfg_cnt_i | input | CNT_W | Number of items still to move |
| preq_burst_i | input | N_CH | Peripheral burst requests |
| preq_single_i | input | N_CH | Peripheral single requests |
| sw_req_i | input | N_CH | Software request pulses |
| cpu_bus_busy_i | input | 1 | Processor owns the bus this cycle |
| grant_o | output | N_CH | One-hot grant to the transfer engine |
| item_stb_o | output | 1 | One item moves this cycle |
| done_o | output | N_CH | Per-channel completion pulses |

## Verification
The checker evaluates several properties on every cycle: the grant is at most one-hot and agrees with the item strobe, nothing is granted while the processor holds the bus, done pulses are one-hot and always follow a strobed item, a finished channel loses its enable, and consecutive granted cycles always belong to the same channel. Some behaviours can only be shown by the directed scenarios, because the expected outcome depends on what was programmed earlier. These are the selection order between priority levels and indices, burst lengths including the clamp at 1024, the effects of the mask and use-burst bits, set/clear collisions, and software requests that must be held pending.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int unsigned EXP_W   = 4;
  localparam int unsigned MAX_EXP = 10;
  localparam int unsigned BURST_W = MAX_EXP + 1;

  function automatic logic [EXP_W-1:0] clamp_exp(input logic [EXP_W-1:0] e);
    return (e > EXP_W'(MAX_EXP)) ? EXP_W'(MAX_EXP) : e;
  endfunction
endpackage

// File: rtl/dma_attr_reg.sv
module dma_attr_reg #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q_o[g] <= 1'b0;
      else if (clr_i[g]) q_o[g] <= 1'b0;  // clear dominates
      else if (set_i[g]) q_o[g] <= 1'b1;
    end
  end
endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     req_i,
  input  logic [N-1:0]     hi_i,
  output logic             vld_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [N-1:0] hi_req, pool;

  assign hi_req = req_i & hi_i;
  assign pool   = (|hi_req) ? hi_req : req_i;
  assign vld_o  = |pool;

  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pool[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/dma_chan_cfg.sv
module dma_chan_cfg
  import dma_arb_pkg::*;
#(
  parameter int N     = 8,
  parameter int IDX_W = 3,
  parameter int CNT_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [IDX_W-1:0] wr_ch_i,
  input  logic [EXP_W-1:0] wr_exp_i,
  input  logic [CNT_W-1:0] wr_cnt_i,
  input  logic             dec_i,
  input  logic [IDX_W-1:0] dec_ch_i,
  input  logic [IDX_W-1:0] rd_ch_i,
  output logic [EXP_W-1:0] rd_exp_o,
  output logic [CNT_W-1:0] rd_rem_o,
  output logic [N-1:0]     rem_nz_o
);
  logic [EXP_W-1:0] exp_q [N];
  logic [CNT_W-1:0] rem_q [N];

  for (genvar g = 0; g < N; g++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        exp_q[g] <= '0;
        rem_q[g] <= '0;
      end else if (wr_i && wr_ch_i == IDX_W'(g)) begin
        exp_q[g] <= wr_exp_i;
        rem_q[g] <= wr_cnt_i;
      end else if (dec_i && dec_ch_i == IDX_W'(g) && rem_q[g] != '0) begin
        rem_q[g] <= rem_q[g] - CNT_W'(1);
      end
    end
    assign rem_nz_o[g] = (rem_q[g] != '0);
  end

  assign rd_exp_o = exp_q[rd_ch_i];
  assign rd_rem_o = rem_q[rd_ch_i];
endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter
  import dma_arb_pkg::*;
#(
  parameter int N_CH  = 8,
  parameter int CNT_W = 11,
  localparam int IDX_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_CH-1:0]  en_set_i,
  input  logic [N_CH-1:0]  en_clr_i,
  input  logic [N_CH-1:0]  mask_set_i,
  input  logic [N_CH-1:0]  mask_clr_i,
  input  logic [N_CH-1:0]  prio_set_i,
  input  logic [N_CH-1:0]  prio_clr_i,
  input  logic [N_CH-1:0]  burst_set_i,
  input  logic [N_CH-1:0]  burst_clr_i,
  input  logic             cfg_we_i,
  input  logic [IDX_W-1:0] cfg_ch_i,
  input  logic [3:0]       cfg_exp_i,
  input  logic [CNT_W-1:0] cfg_cnt_i,
  input  logic [N_CH-1:0]  preq_burst_i,
  input  logic [N_CH-1:0]  preq_single_i,
  input  logic [N_CH-1:0]  sw_req_i,
  input  logic             cpu_bus_busy_i,
  output logic [N_CH-1:0]  grant_o,
  output logic             item_stb_o,
  output logic [N_CH-1:0]  done_o
);
  localparam int LEN_W = (CNT_W > int'(BURST_W)) ? CNT_W : int'(BURST_W);

  logic [N_CH-1:0]  en_q, mask_q, prio_q, ub_q, rem_nz, sw_pend_q;
  logic [N_CH-1:0]  en_clr_eff, eligible, own_vec, start_vec, fin_vec;
  logic             own_q, start, stb, last_item, final_item, pick_vld;
  logic [IDX_W-1:0] own_idx_q, pick_idx, rd_ch;
  logic [EXP_W-1:0] rd_exp;
  logic [CNT_W-1:0] rd_rem;
  logic [LEN_W-1:0] burst_left_q, burst_len, rem_ext, first_len;

  dma_attr_reg #(.N(N_CH)) u_en (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(en_set_i), .clr_i(en_clr_eff), .q_o(en_q));
  dma_attr_reg #(.N(N_CH)) u_mask (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(mask_set_i), .clr_i(mask_clr_i), .q_o(mask_q));
  dma_attr_reg #(.N(N_CH)) u_prio (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(prio_set_i), .clr_i(prio_clr_i), .q_o(prio_q));
  dma_attr_reg #(.N(N_CH)) u_ub (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(burst_set_i), .clr_i(burst_clr_i), .q_o(ub_q));

  dma_chan_cfg #(.N(N_CH), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (cfg_we_i),
    .wr_ch_i  (cfg_ch_i),
    .wr_exp_i (cfg_exp_i),
    .wr_cnt_i (cfg_cnt_i),
    .dec_i    (stb),
    .dec_ch_i (own_idx_q),
    .rd_ch_i  (rd_ch),
    .rd_exp_o (rd_exp),
    .rd_rem_o (rd_rem),
    .rem_nz_o (rem_nz)
  );

  // request qualification: mask gates peripheral side, use-burst drops singles
  assign eligible = en_q & rem_nz &
                    (sw_pend_q | (~mask_q & (preq_burst_i | (preq_single_i & ~ub_q))));

  dma_prio_pick #(.N(N_CH), .IDX_W(IDX_W)) u_pick (
    .req_i (eligible),
    .hi_i  (prio_q),
    .vld_o (pick_vld),
    .idx_o (pick_idx)
  );

  assign start      = !own_q && pick_vld;
  assign rd_ch      = own_q ? own_idx_q : pick_idx;
  assign burst_len  = LEN_W'(1) << clamp_exp(rd_exp);
  assign rem_ext    = LEN_W'(rd_rem);
  assign first_len  = (rem_ext < burst_len) ? rem_ext : burst_len;

  assign stb        = own_q && !cpu_bus_busy_i;
  assign last_item  = stb && burst_left_q == LEN_W'(1);
  assign final_item = stb && rd_rem == CNT_W'(1);

  assign own_vec    = N_CH'(1) << own_idx_q;
  assign start_vec  = start ? (N_CH'(1) << pick_idx) : '0;
  assign fin_vec    = final_item ? own_vec : '0;
  assign en_clr_eff = en_clr_i | fin_vec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      own_q        <= 1'b0;
      own_idx_q    <= '0;
      burst_left_q <= '0;
      done_o       <= '0;
      sw_pend_q    <= '0;
    end else begin
      done_o    <= fin_vec;
      sw_pend_q <= (sw_pend_q & ~start_vec) | sw_req_i;
      if (start) begin
        own_q        <= 1'b1;
        own_idx_q    <= pick_idx;
        burst_left_q <= first_len;
      end else if (stb) begin
        burst_left_q <= burst_left_q - LEN_W'(1);
        if (last_item) own_q <= 1'b0;
      end
    end
  end

  assign grant_o    = stb ? own_vec : '0;
  assign item_stb_o = stb;
endmodule

// File: rtl/dma_req_arbiter_chk.sv
module dma_req_arbiter_chk #(
  parameter int N_CH = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [N_CH-1:0] grant_o,
  input logic            item_stb_o,
  input logic [N_CH-1:0] done_o,
  input logic            cpu_bus_busy_i,
  input logic [N_CH-1:0] en_q
);
  p_grant_onehot_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o));

  p_stb_grant_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    item_stb_o == (grant_o != '0));

  p_yield_cpu_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_bus_busy_i |-> (grant_o == '0 && !item_stb_o));

  p_done_onehot_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(done_o));

  p_done_after_item_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o != '0) |-> $past(item_stb_o));

  p_grant_same_owner_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((grant_o != '0) && ($past(grant_o) != '0)) |-> grant_o == $past(grant_o));

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    p_done_clears_en_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o[g] |-> !en_q[g]);
  end
endmodule

bind dma_req_arbiter dma_req_arbiter_chk #(.N_CH(N_CH)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .grant_o        (grant_o),
  .item_stb_o     (item_stb_o),
  .done_o         (done_o),
  .cpu_bus_busy_i (cpu_bus_busy_i),
  .en_q           (en_q)
);

// File: tb/dma_req_arbiter_bench.sv
`timescale 1ns/1ps
module dma_req_arbiter_bench;
  localparam int N  = 8;
  localparam int CW = 11;
  localparam int IW = 3;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [N-1:0] en_set, en_clr, mask_set, mask_clr, prio_set, prio_clr, ub_set, ub_clr;
  logic [N-1:0] preq_b, preq_s, sw_req, grant, done;
  logic cfg_we, busy, stb;
  logic [IW-1:0] cfg_ch;
  logic [3:0] cfg_exp;
  logic [CW-1:0] cfg_cnt;

  always #4 clk = ~clk;

  dma_req_arbiter #(.N_CH(N), .CNT_W(CW)) u_dma_req_arbiter (
    .clk_i(clk), .rst_ni(rst_ni),
    .en_set_i(en_set), .en_clr_i(en_clr), .mask_set_i(mask_set), .mask_clr_i(mask_clr),
    .prio_set_i(prio_set), .prio_clr_i(prio_clr), .burst_set_i(ub_set), .burst_clr_i(ub_clr),
    .cfg_we_i(cfg_we), .cfg_ch_i(cfg_ch), .cfg_exp_i(cfg_exp), .cfg_cnt_i(cfg_cnt),
    .preq_burst_i(preq_b), .preq_single_i(preq_s), .sw_req_i(sw_req),
    .cpu_bus_busy_i(busy), .grant_o(grant), .item_stb_o(stb), .done_o(done));

  int errors = 0, checks = 0;
  int stb_cnt [N];
  int done_cnt [N];
  int seq [64];
  int seq_n, max_run, run, busy_grant, bad;
  logic [N-1:0] prev_grant;

  // monitor samples at the falling edge; inputs move 1 ns after the rising edge
  always @(negedge clk) begin
    if (rst_ni) begin
      for (int i = 0; i < N; i++) begin
        if (grant[i]) stb_cnt[i]++;
        if (done[i]) done_cnt[i]++;
      end
      if (busy && grant != '0) busy_grant++;
      if (stb != (grant != '0) || !$onehot0(grant)) bad++;
      if (grant != '0) begin
        if (grant == prev_grant) run++;
        else begin
          run = 1;
          for (int i = 0; i < N; i++) if (grant[i] && seq_n < 64) seq[seq_n] = i;
          seq_n++;
        end
        if (run > max_run) max_run = run;
      end else run = 0;
      prev_grant = grant;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    en_set = '0; en_clr = '0; mask_set = '0; mask_clr = '0;
    prio_set = '0; prio_clr = '0; ub_set = '0; ub_clr = '0;
    preq_b = '0; preq_s = '0; sw_req = '0; busy = 1'b0;
    cfg_we = 1'b0; cfg_ch = '0; cfg_exp = '0; cfg_cnt = '0;
    for (int i = 0; i < N; i++) begin stb_cnt[i] = 0; done_cnt[i] = 0; end
    seq_n = 0; max_run = 0; run = 0; busy_grant = 0; bad = 0; prev_grant = '0;
    step(3);
    rst_ni = 1'b1;
    step(1);
  endtask

  task automatic clr_stats();
    for (int i = 0; i < N; i++) begin stb_cnt[i] = 0; done_cnt[i] = 0; end
    seq_n = 0; max_run = 0;
  endtask

  task automatic cfg(input int ch, input int e, input int cnt);
    cfg_we = 1'b1; cfg_ch = IW'(ch); cfg_exp = 4'(e); cfg_cnt = CW'(cnt);
    step(1);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_en(input logic [N-1:0] v);
    en_set = v; step(1); en_set = '0;
  endtask

  task automatic t_reset();
    do_reset();
    chk(grant == '0 && !stb && done == '0, "R1 outputs after reset", int'(grant), 0);
    preq_s = '1; preq_b = '1;
    step(10);
    chk(stb_cnt[0] + stb_cnt[3] + stb_cnt[7] == 0, "R1 no grant without enable", stb_cnt[0], 0);
    chk(bad == 0, "R10 grant/strobe consistency", bad, 0);
  endtask

  task automatic t_basic();
    do_reset();
    cfg(2, 1, 5);
    pulse_en(8'h04);
    preq_s[2] = 1'b1;
    step(20);
    chk(stb_cnt[2] == 5, "R3 items moved", stb_cnt[2], 5);
    chk(max_run == 2, "R7 burst of 2^1", max_run, 2);
    chk(seq_n == 3, "R7 bursts of 2,2,1", seq_n, 3);
    chk(done_cnt[2] == 1, "R9 one done pulse", done_cnt[2], 1);
    clr_stats();
    cfg(2, 1, 3);
    step(10);
    chk(stb_cnt[2] == 0, "R9 enable cleared after done", stb_cnt[2], 0);
  endtask

  task automatic t_prio();
    do_reset();
    for (int c = 0; c < 6; c++) cfg(c, 0, 1);
    pulse_en(8'h2B);
    prio_set = 8'h28; step(1); prio_set = '0;
    preq_s = 8'h2B;
    step(20);
    chk(seq_n == 4, "R6 four grants", seq_n, 4);
    chk(seq[0] == 3, "R6 high level lowest index first", seq[0], 3);
    chk(seq[1] == 5, "R6 high level next", seq[1], 5);
    chk(seq[2] == 0, "R6 default level lowest index", seq[2], 0);
    chk(seq[3] == 1, "R6 default level next", seq[3], 1);
  endtask

  task automatic t_setclr();
    do_reset();
    cfg(4, 0, 2);
    en_set = 8'h10; en_clr = 8'h10; step(1); en_set = '0; en_clr = '0;
    preq_s[4] = 1'b1;
    step(10);
    chk(stb_cnt[4] == 0, "R2 clear wins over set", stb_cnt[4], 0);
    pulse_en(8'h10);
    step(10);
    chk(stb_cnt[4] == 2, "R2 set alone enables", stb_cnt[4], 2);
  endtask

  task automatic t_mask();
    do_reset();
    cfg(6, 0, 2);
    pulse_en(8'h40);
    mask_set = 8'h40; step(1); mask_set = '0;
    preq_s[6] = 1'b1; preq_b[6] = 1'b1;
    step(10);
    chk(stb_cnt[6] == 0, "R4 masked peripheral ignored", stb_cnt[6], 0);
    sw_req[6] = 1'b1; step(1); sw_req = '0;
    step(10);
    chk(stb_cnt[6] == 1, "R4 software accepted while masked", stb_cnt[6], 1);
  endtask

  task automatic t_useburst();
    do_reset();
    cfg(7, 2, 4);
    pulse_en(8'h80);
    ub_set = 8'h80; step(1); ub_set = '0;
    preq_s[7] = 1'b1;
    step(10);
    chk(stb_cnt[7] == 0, "R5 single ignored with use-burst", stb_cnt[7], 0);
    preq_b[7] = 1'b1;
    step(10);
    chk(stb_cnt[7] == 4, "R5 burst request served", stb_cnt[7], 4);
    chk(max_run == 4, "R5 one burst of 4", max_run, 4);
  endtask

  task automatic t_clamp();
    do_reset();
    cfg(0, 15, 1030);
    pulse_en(8'h01);
    preq_s[0] = 1'b1;
    step(1045);
    chk(max_run == 1024, "R7 exponent clamped to 10", max_run, 1024);
    chk(stb_cnt[0] == 1030, "R7 all items moved", stb_cnt[0], 1030);
    chk(done_cnt[0] == 1, "R9 done after clamped run", done_cnt[0], 1);
  endtask

  task automatic t_cpu();
    do_reset();
    cfg(1, 2, 4);
    pulse_en(8'h02);
    busy = 1'b1;
    preq_s[1] = 1'b1;
    step(10);
    chk(stb_cnt[1] == 0, "R8 no grant while busy", stb_cnt[1], 0);
    busy = 1'b0;
    step(2);
    busy = 1'b1;
    step(3);
    busy = 1'b0;
    step(10);
    chk(stb_cnt[1] == 4, "R8 paused burst completes", stb_cnt[1], 4);
    chk(busy_grant == 0, "R8 grant never during busy", busy_grant, 0);
    chk(done_cnt[1] == 1, "R9 done after paused burst", done_cnt[1], 1);
  endtask

  task automatic t_swpend();
    do_reset();
    pulse_en(8'h08);
    sw_req[3] = 1'b1; step(1); sw_req = '0;
    step(5);
    chk(stb_cnt[3] == 0, "R11 zero count not granted", stb_cnt[3], 0);
    cfg(3, 1, 2);
    step(8);
    chk(stb_cnt[3] == 2, "R11 pending request served later", stb_cnt[3], 2);
    chk(bad == 0, "R10 grant/strobe consistency", bad, 0);
  endtask

  bit finished = 1'b0;

  initial begin
    t_reset();
    t_basic();
    t_prio();
    t_setclr();
    t_mask();
    t_useburst();
    t_clamp();
    t_cpu();
    t_swpend();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      finished = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule